// File: doc/BRIEF.md
# Memory-Mapped Switch and Display Bridge

This block sits between a 16-bit processor's memory port and an external asynchronous SRAM. Nearly every access goes straight through: the address is padded to the SRAM's wider address bus, the active-low strobes pass unchanged, and the data moves across whichever bidirectional bus is not being driven. One address, 0xFFFF, is special. A read there returns the state of sixteen board switches instead of SRAM data. A write there loads a 16-bit register whose four nibbles feed a four-digit hexadecimal display.

Input and output share that one address, so the direction of the access (write strobe low or output strobe low) is the only thing that tells them apart. Each bus has its own tristate driver. The bridge drives the SRAM-side bus only during writes. It drives the CPU-side bus only during reads. It also keeps the SRAM's output enable off whenever the write strobe is active, so two drivers never meet on the same wires.

Top module: `mmio_bridge`

## Requirements
- R1: The SRAM address equals the 16-bit CPU address zero-extended to 20 bits, with bits 19..16 always 0.
- R2: The active-low chip enable, upper-byte enable, lower-byte enable and write enable pass to the SRAM unchanged, including for accesses to 0xFFFF.
- R3: The SRAM output enable (active low) is forced high while the CPU write enable is low; otherwise it follows the CPU output enable.
- R4: While the CPU output enable is low, the write enable is high and the address is not 0xFFFF, the CPU data bus carries the SRAM data bus.
- R5: While the CPU output enable is low, the write enable is high and the address is 0xFFFF, the CPU data bus carries the switch inputs, whatever the SRAM holds.
- R6: While the CPU write enable is low, the SRAM data bus carries the CPU data, and the bridge never drives both buses at once.
- R7: On each rising clock edge where the write enable is low and the address is 0xFFFF, the display register loads the CPU data bus.
- R8: The display register holds its value across writes to any other address, and across reads or idle cycles at any address.
- R9: An active-low reset clears the display register to 0x0000 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the display register |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_data | inout | 16 | Processor data bus, driven by the bridge only during reads |
| cpu_ce_n | input | 1 | Chip enable from processor, active low |
| cpu_ub_n | input | 1 | Upper-byte enable from processor, active low |
| cpu_lb_n | input | 1 | Lower-byte enable from processor, active low |
| cpu_oe_n | input | 1 | Output (read) enable from processor, active low |
| cpu_we_n | input | 1 | Write enable from processor, active low |
| switches | input | 16 | Board switch levels, read at 0xFFFF |
| sram_addr | output | 20 | SRAM address |
| sram_data | inout | 16 | SRAM data bus, driven by the bridge only during writes |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_ub_n | output | 1 | SRAM upper-byte enable, active low |
| sram_lb_n | output | 1 | SRAM lower-byte enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| disp_value | output | 16 | Value held for the four-digit display |

## Verification
The bench targets the cycles where output enable and write enable are both low. There, a bridge that ignored write priority would leave the SRAM output enable active and set both drivers against each other. It drives reads at 0xFFFF while the SRAM model holds a different word, which exposes a decoder that lets SRAM data through. It also writes to 0xFFFE and reads 0xFFFF after a display write, catching a loose address compare or a register that loads on reads. Finally, it pulls reset between clock edges to show the display clears asynchronously, and checks that the upper SRAM address bits stay at zero for high addresses.

// File: rtl/mmio_bridge_pkg.sv
package mmio_bridge_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_MEM_READ,
        ACC_MEM_WRITE,
        ACC_IO_READ,
        ACC_IO_WRITE
    } acc_kind_e;

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
    import mmio_bridge_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] IO_ADDR = 16'hFFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic              we_n,
    output acc_kind_e         kind
);

    logic hit_io;

    assign hit_io = (addr == IO_ADDR[ADDR_W-1:0]);

    // Write strobe wins over output strobe.
    always_comb begin
        if (!we_n)
            kind = hit_io ? ACC_IO_WRITE : ACC_MEM_WRITE;
        else if (!oe_n)
            kind = hit_io ? ACC_IO_READ : ACC_MEM_READ;
        else
            kind = ACC_IDLE;
    end

endmodule

// File: rtl/mmio_data_steer.sv
module mmio_data_steer
    import mmio_bridge_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] sram_rd,
    input  logic [DATA_W-1:0] sw_rd,
    input  logic [DATA_W-1:0] cpu_wr,
    output logic [DATA_W-1:0] cpu_out,
    output logic              cpu_out_en,
    output logic [DATA_W-1:0] sram_out,
    output logic              sram_out_en
);

    always_comb begin
        cpu_out     = '0;
        cpu_out_en  = 1'b0;
        sram_out    = cpu_wr;
        sram_out_en = 1'b0;
        unique case (kind)
            ACC_MEM_READ: begin
                cpu_out    = sram_rd;
                cpu_out_en = 1'b1;
            end
            ACC_IO_READ: begin
                cpu_out    = sw_rd;
                cpu_out_en = 1'b1;
            end
            ACC_MEM_WRITE,
            ACC_IO_WRITE: begin
                sram_out_en = 1'b1;
            end
            default: begin
                cpu_out_en  = 1'b0;
                sram_out_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mmio_display_reg.sv
module mmio_display_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end

    // R7
    disp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(din)));

    // R8
    disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge
    import mmio_bridge_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          EXT_ADDR_W = 20,
    parameter int          DATA_W     = 16,
    parameter logic [15:0] IO_ADDR    = 16'hFFFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cpu_addr,
    inout  wire  [DATA_W-1:0]     cpu_data,
    input  logic                  cpu_ce_n,
    input  logic                  cpu_ub_n,
    input  logic                  cpu_lb_n,
    input  logic                  cpu_oe_n,
    input  logic                  cpu_we_n,
    input  logic [DATA_W-1:0]     switches,
    output logic [EXT_ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0]     sram_data,
    output logic                  sram_ce_n,
    output logic                  sram_ub_n,
    output logic                  sram_lb_n,
    output logic                  sram_oe_n,
    output logic                  sram_we_n,
    output logic [DATA_W-1:0]     disp_value
);

    localparam int PAD_W = EXT_ADDR_W - ADDR_W;

    acc_kind_e         kind;
    logic [DATA_W-1:0] cpu_drv_val;
    logic              cpu_drv_en;
    logic [DATA_W-1:0] sram_drv_val;
    logic              sram_drv_en;
    logic              disp_load;

    assign sram_addr = {{PAD_W{1'b0}}, cpu_addr};
    assign sram_ce_n = cpu_ce_n;
    assign sram_ub_n = cpu_ub_n;
    assign sram_lb_n = cpu_lb_n;
    assign sram_we_n = cpu_we_n;
    assign sram_oe_n = cpu_oe_n | ~cpu_we_n;

    mmio_addr_decode #(
        .ADDR_W  (ADDR_W),
        .IO_ADDR (IO_ADDR)
    ) u_decode (
        .addr (cpu_addr),
        .oe_n (cpu_oe_n),
        .we_n (cpu_we_n),
        .kind (kind)
    );

    mmio_data_steer #(
        .DATA_W (DATA_W)
    ) u_steer (
        .kind        (kind),
        .sram_rd     (sram_data),
        .sw_rd       (switches),
        .cpu_wr      (cpu_data),
        .cpu_out     (cpu_drv_val),
        .cpu_out_en  (cpu_drv_en),
        .sram_out    (sram_drv_val),
        .sram_out_en (sram_drv_en)
    );

    assign cpu_data  = cpu_drv_en  ? cpu_drv_val  : {DATA_W{1'bz}};
    assign sram_data = sram_drv_en ? sram_drv_val : {DATA_W{1'bz}};

    assign disp_load = (kind == ACC_IO_WRITE);

    mmio_display_reg #(
        .DATA_W (DATA_W)
    ) u_disp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (disp_load),
        .din   (cpu_data),
        .q     (disp_value)
    );

    // R3
    oe_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we_n |-> sram_oe_n);

    // R6
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_drv_en && sram_drv_en));

    // R5
    io_read_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_drv_en && cpu_addr == IO_ADDR[ADDR_W-1:0]) |-> (cpu_drv_val == switches));

    // R6
    write_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we_n |-> (sram_drv_en && !cpu_drv_en));

endmodule

// File: tb/mmio_bridge_bench.sv
module mmio_bridge_bench;

    typedef struct {
        int          kind;
        logic [19:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_ce_n = 1'b1;
    logic        cpu_ub_n = 1'b1;
    logic        cpu_lb_n = 1'b1;
    logic        cpu_oe_n = 1'b1;
    logic        cpu_we_n = 1'b1;
    logic [15:0] switches = '0;
    logic [15:0] tb_wdata = '0;
    wire  [15:0] cpu_data;
    wire  [15:0] sram_data;
    logic [19:0] sram_addr;
    logic        sram_ce_n, sram_ub_n, sram_lb_n, sram_oe_n, sram_we_n;
    logic [15:0] disp_value;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    item_t q[$];
    event  chk_ev;

    always #5 clk = ~clk;

    function automatic logic [15:0] sram_word(input logic [19:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C96;
    endfunction

    assign cpu_data  = !cpu_we_n ? tb_wdata : 16'hzzzz;
    assign sram_data = (!sram_ce_n && !sram_oe_n && sram_we_n) ? sram_word(sram_addr) : 16'hzzzz;

    mmio_bridge u_mmio_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_data   (cpu_data),
        .cpu_ce_n   (cpu_ce_n),
        .cpu_ub_n   (cpu_ub_n),
        .cpu_lb_n   (cpu_lb_n),
        .cpu_oe_n   (cpu_oe_n),
        .cpu_we_n   (cpu_we_n),
        .switches   (switches),
        .sram_addr  (sram_addr),
        .sram_data  (sram_data),
        .sram_ce_n  (sram_ce_n),
        .sram_ub_n  (sram_ub_n),
        .sram_lb_n  (sram_lb_n),
        .sram_oe_n  (sram_oe_n),
        .sram_we_n  (sram_we_n),
        .disp_value (disp_value)
    );

    function automatic logic [19:0] observe(input int kind);
        case (kind)
            0: return {4'h0, cpu_data};
            1: return {4'h0, sram_data};
            2: return sram_addr;
            3: return {19'h0, sram_oe_n};
            4: return {19'h0, sram_we_n};
            5: return {19'h0, sram_ce_n};
            6: return {19'h0, sram_ub_n};
            7: return {19'h0, sram_lb_n};
            default: return {4'h0, disp_value};
        endcase
    endfunction

    task automatic expect_item(input int kind, input logic [19:0] exp, input string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        q.push_back(it);
    endtask

    // monitor: pops expectations once outputs have settled
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (q.size() != 0) begin
                item_t it;
                logic [19:0] got;
                it  = q.pop_front();
                got = observe(it.kind);
                n_checks++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: kind %0d got %h expected %h", it.req, it.kind, got, it.exp);
                end
            end
        end
    end

    task automatic drive(input logic [15:0] a, input logic oe_n, input logic we_n,
                         input logic [15:0] wd, input logic [15:0] sw,
                         input logic ub_n, input logic lb_n);
        @(negedge clk);
        cpu_addr = a;
        cpu_oe_n = oe_n;
        cpu_we_n = we_n;
        cpu_ce_n = 1'b0;
        cpu_ub_n = ub_n;
        cpu_lb_n = lb_n;
        tb_wdata = wd;
        switches = sw;
        #1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        cpu_oe_n = 1'b1;
        cpu_we_n = 1'b1;
        cpu_ce_n = 1'b1;
        #1;
    endtask

    task automatic fire();
        -> chk_ev;
        #2;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset value
        expect_item(8, 20'h0, "R9 reset value");
        fire();

        // R4, R1, R2, R3: memory read
        drive(16'h1234, 1'b0, 1'b1, 16'h0, 16'hBEEF, 1'b0, 1'b1);
        expect_item(0, {4'h0, sram_word(20'h01234)}, "R4 mem read data");
        expect_item(2, 20'h01234, "R1 address extension");
        expect_item(3, 20'h0, "R3 oe follows cpu");
        expect_item(6, 20'h0, "R2 ub pass");
        expect_item(7, 20'h1, "R2 lb pass");
        expect_item(5, 20'h0, "R2 ce pass");
        fire();

        drive(16'h8001, 1'b0, 1'b1, 16'h0, 16'hBEEF, 1'b1, 1'b0);
        expect_item(0, {4'h0, sram_word(20'h08001)}, "R4 mem read high addr");
        expect_item(2, 20'h08001, "R1 upper bits zero");
        expect_item(6, 20'h1, "R2 ub pass");
        fire();

        // R5: switch read at 0xFFFF
        drive(16'hFFFF, 1'b0, 1'b1, 16'h0, 16'hBEEF, 1'b0, 1'b0);
        expect_item(0, 20'h0BEEF, "R5 switch read");
        expect_item(2, 20'h0FFFF, "R1 io address");
        expect_item(3, 20'h0, "R2 io read strobe passes");
        fire();
        drive(16'hFFFF, 1'b0, 1'b1, 16'h0, 16'h0F0F, 1'b0, 1'b0);
        expect_item(0, 20'h00F0F, "R5 switch read second");
        fire();
        go_idle();
        expect_item(8, 20'h0, "R8 reads leave display");
        fire();

        // R6, R3: memory write with oe also low; R8 display untouched
        drive(16'h0042, 1'b0, 1'b0, 16'h5A5A, 16'h0, 1'b0, 1'b0);
        expect_item(1, 20'h05A5A, "R6 write data on sram bus");
        expect_item(4, 20'h0, "R2 we pass");
        expect_item(3, 20'h1, "R3 we overrides oe");
        fire();
        go_idle();
        expect_item(8, 20'h0, "R8 mem write leaves display");
        expect_item(3, 20'h1, "R3 idle oe high");
        fire();

        // R7: display write
        drive(16'hFFFF, 1'b1, 1'b0, 16'hC0DE, 16'h1111, 1'b0, 1'b0);
        expect_item(1, 20'h0C0DE, "R6 io write reaches sram");
        expect_item(4, 20'h0, "R2 io write strobe passes");
        fire();
        go_idle();
        expect_item(8, 20'h0C0DE, "R7 display load");
        fire();

        // R8: read of 0xFFFF must not disturb display
        drive(16'hFFFF, 1'b0, 1'b1, 16'h0, 16'h2222, 1'b0, 1'b0);
        expect_item(0, 20'h02222, "R5 switch read after write");
        fire();
        go_idle();
        expect_item(8, 20'h0C0DE, "R8 io read keeps display");
        fire();

        // R7 with oe low too, R3 priority
        drive(16'hFFFF, 1'b0, 1'b0, 16'h1357, 16'h0, 1'b0, 1'b0);
        expect_item(3, 20'h1, "R3 io write oe forced high");
        fire();
        go_idle();
        expect_item(8, 20'h01357, "R7 display load oe low");
        fire();

        // R8: neighbour address write
        drive(16'hFFFE, 1'b1, 1'b0, 16'h9999, 16'h0, 1'b0, 1'b0);
        expect_item(1, 20'h09999, "R6 write neighbour");
        fire();
        go_idle();
        expect_item(8, 20'h01357, "R8 neighbour write ignored");
        fire();

        // R9: asynchronous clear between edges
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        expect_item(8, 20'h0, "R9 async clear");
        fire();
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule